// File: doc/BRIEF.md
# Multi-Stream Sequential Prefetch Buffer

This unit sits beside an instruction or data cache and holds blocks fetched ahead of demand. Each cache miss is presented to it first. When the missing block sits at the head of one of its streams, the block is handed back with no memory access, and the stream moves on by one block and queues a fetch of that next block. When no stream holds the block, the unit sends one demand fetch to memory and returns the reply. It also reclaims the least recently used stream, points it at the block after the missed one and queues a fetch of that block.

The cache offers one miss at a time and waits for the matching return pulse. Memory requests carry a prefetch flag and a stream number, and memory echoes them with the address and the data. It may answer after any latency, provided it answers in the order it accepted the requests. Prefetches only use request slots that no demand fetch wants. The number of streams is a parameter (1, 4 and 8 are typical), and blocks are modelled as one data word per block address.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset, miss_ready is 1, ret_valid is 0, mem_req_valid is 0, and every stream is empty, so the first miss always goes to memory.
- R2: A miss whose address matches no stream head produces exactly one memory request with mem_req_pf = 0 at that address. Its reply is returned with ret_hit = 0.
- R3: Such a miss reclaims a stream and sets its head to the missed address plus one. A prefetch of that head is queued with mem_req_pf = 1 and mem_req_stream set to the stream number. The reclaimed stream number is reported on ret_stream.
- R4: The reclaimed stream is the least recently used one. Both hits and reclaims count as use. Right after reset the victims come in the order NS-1, NS-2, ... down to 0.
- R5: A miss whose address equals a valid stream head is returned with ret_hit = 1, the stream number on ret_stream, and the stored data. No demand request is made.
- R6: After a hit, that stream's head becomes the hit address plus one and a prefetch of it is queued.
- R7: When several stream heads equal the miss address, the lowest-numbered stream serves it.
- R8: In any cycle where a demand request and a queued prefetch both want the memory port, the demand request is the one presented.
- R9: A hit on a head whose fetch is still outstanding waits for that data. It issues no further request for the block.
- R10: A prefetch reply is stored only if its stream is still waiting for that address. A reply for a head that has since been replaced is dropped. Returned data always equals memory's content for ret_addr.
- R11: Each accepted miss yields exactly one ret_valid pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_addr | input | AW | Block address of the miss |
| miss_ready | output | 1 | Unit can accept a miss |
| ret_valid | output | 1 | One-cycle return pulse |
| ret_addr | output | AW | Block address being returned |
| ret_data | output | DW | Block data |
| ret_hit | output | 1 | 1 = served from a stream, 0 = from memory |
| ret_stream | output | SW | Stream that served or was reclaimed |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Requested block address |
| mem_req_pf | output | 1 | 1 = prefetch, 0 = demand |
| mem_req_stream | output | SW | Stream of a prefetch |
| mem_rsp_valid | input | 1 | Memory reply present |
| mem_rsp_addr | input | AW | Echoed block address |
| mem_rsp_pf | input | 1 | Echoed prefetch flag |
| mem_rsp_stream | input | SW | Echoed stream number |
| mem_rsp_data | input | DW | Reply data |

## Verification
A freshly reclaimed stream queues its prefetch in the same cycle the unit raises its demand fetch, so the two compete for the one memory port. The bench provokes this by holding mem_req_ready low across a miss. It then checks that the request shown two cycles after the miss is accepted is the demand at the missed address, not the waiting prefetch. Random stimulus with random ready stalls and reply latencies causes the second overlap. A new miss then reclaims a stream while that stream's previous prefetch is still in flight. The bench judges this by the returned data and by the final count of demand requests.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_DEMAND,
    ST_WAIT_MEM,
    ST_WAIT_PEND
  } spb_state_t;
endpackage

// File: rtl/spb_match.sv
module spb_match #(
  parameter int NS = 4,
  parameter int AW = 16,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [NS-1:0] vld,
  input  logic [AW-1:0] head [NS],
  input  logic [AW-1:0] key,
  output logic          hit,
  output logic [SW-1:0] hit_idx
);
  logic [NS-1:0] hv;

  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign hv[g] = vld[g] && (head[g] == key);
  end

  // lowest index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (hv[i]) begin
        hit     = 1'b1;
        hit_idx = SW'(i);
      end
    end
  end
endmodule

// File: rtl/spb_lru.sv
module spb_lru #(
  parameter int NS = 4,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [SW-1:0] touch_idx,
  output logic [SW-1:0] victim
);
  logic [SW-1:0] age [NS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) age[i] <= SW'(i);
    end else if (touch) begin
      for (int i = 0; i < NS; i++) begin
        if (SW'(i) == touch_idx)       age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + SW'(1);
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < NS; i++)
      if (age[i] == SW'(NS - 1)) victim = SW'(i);
  end
endmodule

// File: rtl/spb_pf_pick.sv
module spb_pf_pick #(
  parameter int NS = 4,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [NS-1:0] need,
  output logic          any,
  output logic [SW-1:0] idx
);
  always_comb begin
    any = |need;
    idx = '0;
    for (int i = NS - 1; i >= 0; i--)
      if (need[i]) idx = SW'(i);
  end
endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
  import spb_pkg::*;
#(
  parameter int NS = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  output logic          miss_ready,
  output logic          ret_valid,
  output logic [AW-1:0] ret_addr,
  output logic [DW-1:0] ret_data,
  output logic          ret_hit,
  output logic [SW-1:0] ret_stream,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_pf,
  output logic [SW-1:0] mem_req_stream,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_addr,
  input  logic          mem_rsp_pf,
  input  logic [SW-1:0] mem_rsp_stream,
  input  logic [DW-1:0] mem_rsp_data
);
  function automatic logic [AW-1:0] next_blk(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  spb_state_t    st;
  logic [AW-1:0] cur_addr;
  logic [SW-1:0] cur_idx;
  logic [NS-1:0] sv, spend, sneed;
  logic [AW-1:0] saddr [NS];
  logic [DW-1:0] sdata [NS];

  // named internal events
  logic          hit, pf_any, dem_want, pf_issue;
  logic [SW-1:0] hit_idx, victim, pf_idx;
  logic          hit_evt, hit_stall, alloc_evt;
  logic [NS-1:0] fill_vec;

  spb_match #(.NS(NS), .AW(AW)) u_match (
    .vld(sv), .head(saddr), .key(cur_addr), .hit(hit), .hit_idx(hit_idx)
  );

  spb_lru #(.NS(NS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(hit_evt | alloc_evt),
    .touch_idx(hit_evt ? hit_idx : victim), .victim(victim)
  );

  spb_pf_pick #(.NS(NS)) u_pick (.need(sneed), .any(pf_any), .idx(pf_idx));

  assign hit_evt   = (st == ST_LOOK) && hit && !spend[hit_idx];
  assign hit_stall = (st == ST_LOOK) && hit &&  spend[hit_idx];
  assign alloc_evt = (st == ST_LOOK) && !hit;
  assign dem_want  = (st == ST_DEMAND);
  assign pf_issue  = pf_any && !dem_want && mem_req_ready;

  assign miss_ready     = (st == ST_IDLE);
  assign mem_req_valid  = dem_want || pf_any;
  assign mem_req_pf     = !dem_want;
  assign mem_req_stream = dem_want ? '0 : pf_idx;
  assign mem_req_addr   = dem_want ? cur_addr : saddr[pf_idx];

  for (genvar g = 0; g < NS; g++) begin : g_fill
    assign fill_vec[g] = mem_rsp_valid && mem_rsp_pf && (mem_rsp_stream == SW'(g))
                         && spend[g] && !sneed[g] && (saddr[g] == mem_rsp_addr);
  end

  // stream state: fill, then issue, then hit / reclaim (later wins)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv    <= '0;
      spend <= '0;
      sneed <= '0;
      for (int i = 0; i < NS; i++) begin
        saddr[i] <= '0;
        sdata[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NS; i++) begin
        if (fill_vec[i]) begin
          sdata[i] <= mem_rsp_data;
          spend[i] <= 1'b0;
        end
        if (pf_issue && pf_idx == SW'(i)) sneed[i] <= 1'b0;
        if ((hit_evt && hit_idx == SW'(i)) || (alloc_evt && victim == SW'(i))) begin
          sv[i]    <= 1'b1;
          spend[i] <= 1'b1;
          sneed[i] <= 1'b1;
          saddr[i] <= next_blk(cur_addr);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_addr   <= '0;
      cur_idx    <= '0;
      ret_valid  <= 1'b0;
      ret_addr   <= '0;
      ret_data   <= '0;
      ret_hit    <= 1'b0;
      ret_stream <= '0;
    end else begin
      ret_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (miss_valid) begin
          cur_addr <= miss_addr;
          st       <= ST_LOOK;
        end
        ST_LOOK: begin
          if (hit_evt) begin
            ret_valid  <= 1'b1;
            ret_hit    <= 1'b1;
            ret_stream <= hit_idx;
            ret_addr   <= cur_addr;
            ret_data   <= sdata[hit_idx];
            st         <= ST_IDLE;
          end else if (hit_stall) begin
            cur_idx <= hit_idx;
            st      <= ST_WAIT_PEND;
          end else begin
            cur_idx <= victim;
            st      <= ST_DEMAND;
          end
        end
        ST_DEMAND: if (mem_req_ready) st <= ST_WAIT_MEM;
        ST_WAIT_MEM: if (mem_rsp_valid && !mem_rsp_pf) begin
          ret_valid  <= 1'b1;
          ret_hit    <= 1'b0;
          ret_stream <= cur_idx;
          ret_addr   <= cur_addr;
          ret_data   <= mem_rsp_data;
          st         <= ST_IDLE;
        end
        ST_WAIT_PEND: if (!spend[cur_idx]) st <= ST_LOOK;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
  parameter int NS = 4,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dem_want,
  input logic          pf_any,
  input logic          mem_req_valid,
  input logic          mem_req_pf,
  input logic          hit_evt,
  input logic          hit_stall,
  input logic          alloc_evt,
  input logic [SW-1:0] hit_idx,
  input logic [SW-1:0] victim,
  input logic [NS-1:0] sneed,
  input logic          ret_valid
);
  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_want && pf_any) |-> (mem_req_valid && !mem_req_pf)); // R8
  AST_HIT_NO_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> !(mem_req_valid && !mem_req_pf)); // R5
  AST_HIT_QUEUES_PF: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> sneed[$past(hit_idx)]); // R6
  AST_ALLOC_QUEUES_PF: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_evt |=> sneed[$past(victim)]); // R3
  AST_STALL_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stall |=> !(mem_req_valid && !mem_req_pf)); // R9
  AST_RET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !ret_valid); // R11
endmodule

bind stream_prefetch_buf spb_checker #(.NS(NS)) u_spb_chk (
  .clk(clk), .rst_n(rst_n), .dem_want(dem_want), .pf_any(pf_any),
  .mem_req_valid(mem_req_valid), .mem_req_pf(mem_req_pf),
  .hit_evt(hit_evt), .hit_stall(hit_stall), .alloc_evt(alloc_evt),
  .hit_idx(hit_idx), .victim(victim), .sneed(sneed), .ret_valid(ret_valid)
);

// File: tb/stream_prefetch_buf_tb_top.sv
`timescale 1ns/1ps
module stream_prefetch_buf_tb_top;
  localparam int NS = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = 2;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0; logic [AW-1:0] miss_addr = '0; logic miss_ready;
  logic ret_valid, ret_hit; logic [AW-1:0] ret_addr; logic [DW-1:0] ret_data;
  logic [SW-1:0] ret_stream;
  logic mem_req_valid, mem_req_pf; logic mem_req_ready = 0;
  logic [AW-1:0] mem_req_addr; logic [SW-1:0] mem_req_stream;
  logic mem_rsp_valid = 0, mem_rsp_pf = 0; logic [AW-1:0] mem_rsp_addr = '0;
  logic [SW-1:0] mem_rsp_stream = '0; logic [DW-1:0] mem_rsp_data = '0;

  stream_prefetch_buf #(.NS(NS), .AW(AW), .DW(DW)) dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int dem_cnt = 0, exp_miss = 0, rets = 0, accepted = 0;
  bit hold = 1, rand_ready = 0, done = 0;
  logic [AW-1:0] cur_miss = '0;

  // bench memory content
  function automatic logic [DW-1:0] memfn(input logic [AW-1:0] a);
    return ({16'h0, a} * 32'h9E3779B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference stream model
  bit            m_v   [NS];
  logic [AW-1:0] m_a   [NS];
  int            m_age [NS];

  function automatic void model_reset();
    for (int i = 0; i < NS; i++) begin m_v[i] = 0; m_a[i] = '0; m_age[i] = i; end
  endfunction

  function automatic void model_use(input int s);
    for (int j = 0; j < NS; j++) if (j != s && m_age[j] < m_age[s]) m_age[j]++;
    m_age[s] = 0;
  endfunction

  function automatic void model_miss(input logic [AW-1:0] a, output bit h, output int s);
    h = 0; s = 0;
    for (int i = 0; i < NS && !h; i++) if (m_v[i] && m_a[i] == a) begin h = 1; s = i; end
    if (!h) for (int i = 0; i < NS; i++) if (m_age[i] == NS - 1) s = i;
    m_v[s] = 1; m_a[s] = a + 16'd1;
    model_use(s);
  endfunction

  // memory model: in order, random latency
  int            q_due[$]; logic [AW-1:0] q_addr[$]; bit q_pf[$]; logic [SW-1:0] q_str[$];
  int last_due = 0;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    mem_rsp_valid = 0;
    if (q_due.size() > 0 && q_due[0] <= cyc) begin
      mem_rsp_valid  = 1;
      mem_rsp_addr   = q_addr.pop_front();
      mem_rsp_pf     = q_pf.pop_front();
      mem_rsp_stream = q_str.pop_front();
      mem_rsp_data   = memfn(mem_rsp_addr);
      void'(q_due.pop_front());
    end
    mem_req_ready = hold ? 1'b0 : (rand_ready ? ($urandom % 4 != 0) : 1'b1);
    if (rst_n && mem_req_valid && mem_req_ready) begin
      int lat;
      lat = rand_ready ? 1 + int'($urandom % 6) : 2;
      last_due = (cyc + lat > last_due + 1) ? cyc + lat : last_due + 1;
      q_due.push_back(last_due); q_addr.push_back(mem_req_addr);
      q_pf.push_back(mem_req_pf); q_str.push_back(mem_req_stream);
      if (!mem_req_pf) begin
        dem_cnt++;
        check(mem_req_addr == cur_miss, "R2", "demand address", mem_req_addr, cur_miss);
      end
    end
  end

  task automatic do_miss(input logic [AW-1:0] a, input bit chk_demand);
    bit eh; int es;
    model_miss(a, eh, es);
    if (!eh) exp_miss++;
    cur_miss = a;
    @(negedge clk); miss_valid = 1; miss_addr = a;
    while (!miss_ready) @(negedge clk);
    @(posedge clk); accepted++;
    @(negedge clk); miss_valid = 0;
    if (chk_demand) begin
      @(negedge clk);
      check(mem_req_valid && !mem_req_pf && mem_req_addr == a, "R8",
            "demand shown over queued prefetch", {mem_req_valid, mem_req_pf}, 2'b10);
      hold = 0;
    end
    do @(negedge clk); while (!ret_valid);
    rets++;
    check(ret_hit == eh, "R2 R5", "hit flag", ret_hit, eh);
    check(ret_stream == SW'(es), "R3 R4 R6 R7", "stream", ret_stream, es);
    check(ret_addr == a, "R11", "return address", ret_addr, a);
    check(ret_data == memfn(a), "R10", "return data", ret_data, memfn(a));
    @(negedge clk);
    check(!ret_valid, "R11", "return pulse width", ret_valid, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  logic [AW-1:0] cursor [4];

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(miss_ready == 1, "R1", "miss_ready after reset", miss_ready, 1);
    check(ret_valid == 0, "R1", "ret_valid after reset", ret_valid, 0);
    check(mem_req_valid == 0, "R1", "no request after reset", mem_req_valid, 0);

    // directed: first miss with memory stalled, demand vs prefetch contention
    hold = 1;
    do_miss(16'd100, 1);
    // sequential run: hits, first one likely on a pending head
    do_miss(16'd101, 0);
    do_miss(16'd102, 0);
    do_miss(16'd103, 0);
    // fill the other streams, then reclaim the oldest
    do_miss(16'd200, 0);
    do_miss(16'd300, 0);
    do_miss(16'd400, 0);
    do_miss(16'd500, 0);
    // two heads with the same address: lowest number serves
    do_miss(16'd700, 0);
    do_miss(16'd700, 0);
    do_miss(16'd701, 0);
    do_miss(16'd702, 0);

    // random phase
    rand_ready = 1;
    for (int k = 0; k < 4; k++) cursor[k] = AW'($urandom % 64);
    for (int n = 0; n < 400; n++) begin
      int c;
      c = int'($urandom % 4);
      if ($urandom % 10 < 7) begin
        do_miss(cursor[c], 0);
        cursor[c] = cursor[c] + 16'd1;
      end else begin
        cursor[c] = AW'($urandom % 64);
        do_miss(cursor[c], 0);
      end
    end

    repeat (20) @(negedge clk);
    check(dem_cnt == exp_miss, "R9", "demand request count", dem_cnt, exp_miss);
    check(rets == accepted, "R11", "returns per accepted miss", rets, accepted);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule